// File: doc/BRIEF.md
# Tag-Renaming Reservation Station Core

This block is a small out-of-order execution core. It takes an in-order stream of register-to-register instructions, one per cycle at most, and parks each one in a reservation station that belongs to the functional unit able to run it. An adder unit serves add, subtract and bitwise AND. A multiplier unit serves multiply. Each station's number, plus one, is the tag that names the result the station will produce. When a station is filled, that tag is written into the destination register's entry. A later reader of the register therefore picks up the tag rather than a stale value.

A source operand is captured either as a value or as a producer tag. Stations wait until both operands are values and their unit is idle, then execute for a fixed number of cycles. Finished results are broadcast on one shared result bus as a value plus the producer's tag. Every waiting station and the register file watch that bus. A register accepts a broadcast only while it still names that producer. This renaming removes write-after-read and write-after-write hazards, so issue stalls only for lack of a free station.

Top module: `rsb_core`

## Requirements
- R1: After reset, register r holds (3*r+1) truncated to DW bits with no pending producer, no result is on the bus, and issue is accepted.
- R2: Opcode 0 computes src1+src2, 1 computes src1-src2, 2 computes src1 AND src2, 3 computes src1*src2; all results are kept to the low DW bits.
- R3: Stations 0..ADD_RS-1 serve opcodes 0..2 and stations ADD_RS..ADD_RS+MUL_RS-1 serve opcode 3; the lowest-numbered empty station of the right kind is filled, and station s broadcasts with tag s+1 (tag 0 means no producer).
- R4: in_ready is low only when no station of the kind needed by in_op is empty; a station that broadcasts becomes reusable from the next cycle.
- R5: Issuing an instruction marks its destination pending until its producer broadcasts; final register contents equal strict program-order execution despite anti and output dependences.
- R6: A broadcast whose tag differs from the tag a register currently names leaves that register's value unchanged.
- R7: A result broadcast in the same cycle an instruction reads its source registers is taken by the new station, so it never waits on an already delivered tag.
- R8: At most one result is broadcast per cycle; when several are finished, the earliest issued one goes first.
- R9: With ready operands and an idle unit, an instruction accepted at clock edge E is first on the bus in the cycle after edge E+LAT, where LAT is ADD_LAT or MUL_LAT.
- R10: A station starts execution only when both operands are values and its unit is idle, and only a station that is executing can broadcast.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction offered |
| in_op | input | 2 | Opcode (0 add, 1 sub, 2 and, 3 mul) |
| in_dst | input | $clog2(NREG) | Destination register |
| in_src1 | input | $clog2(NREG) | First source register |
| in_src2 | input | $clog2(NREG) | Second source register |
| in_ready | output | 1 | A station of the needed kind is free |
| rd_addr | input | $clog2(NREG) | Register observation address |
| rd_val | output | DW | Value held in the observed register |
| rd_busy | output | 1 | Observed register awaits a producer |
| cdb_valid | output | 1 | Result bus carries a result |
| cdb_tag | output | $clog2(ADD_RS+MUL_RS+1) | Producer tag on the bus |
| cdb_data | output | DW | Result value on the bus |

## Verification
The bench builds the core with its defaults: eight 16-bit registers, two adder and two multiplier stations, an adder latency of 1 and a multiplier latency of 3. With this latency gap, a multiply and a later add can be made to finish in the same cycle, which tests oldest-first bus ordering. Two multiplier stations fill after two dependent multiplies, so a stall is easy to reach. A short fast overwriter of a slow producer's destination exercises the stale broadcast case.

// File: rtl/rsb_pkg.sv
package rsb_pkg;
  localparam int SEQ_W = 8;

  typedef enum logic [1:0] {OP_ADD = 2'd0, OP_SUB = 2'd1, OP_AND = 2'd2, OP_MUL = 2'd3} op_e;
  typedef enum logic [1:0] {ST_EMPTY = 2'd0, ST_WAIT = 2'd1, ST_EXEC = 2'd2} st_e;

  // Arithmetic of both units, on a 32-bit carrier.
  function automatic logic [31:0] op_eval(op_e op, logic [31:0] a, logic [31:0] b);
    case (op)
      OP_ADD:  return a + b;
      OP_SUB:  return a - b;
      OP_AND:  return a & b;
      default: return a * b;
    endcase
  endfunction

  // Value a register holds out of reset.
  function automatic logic [31:0] reg_init(int r);
    return 32'(r * 3 + 1);
  endfunction

  // Wrap-aware age compare of issue sequence numbers.
  function automatic logic seq_older(logic [SEQ_W-1:0] a, logic [SEQ_W-1:0] b);
    logic [SEQ_W-1:0] d;
    d = a - b;
    return d[SEQ_W-1];
  endfunction
endpackage

// File: rtl/rsb_regfile.sv
module rsb_regfile import rsb_pkg::*; #(
  parameter int NREG = 8,
  parameter int DW   = 16,
  parameter int TW   = 3,
  localparam int RW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [RW-1:0] ra1,
  input  logic [RW-1:0] ra2,
  output logic [DW-1:0] rv1,
  output logic [TW-1:0] rt1,
  output logic [DW-1:0] rv2,
  output logic [TW-1:0] rt2,
  input  logic [RW-1:0] obs_addr,
  output logic [DW-1:0] obs_val,
  output logic          obs_busy,
  input  logic          alloc_en,
  input  logic [RW-1:0] alloc_dst,
  input  logic [TW-1:0] alloc_tag,
  input  logic          cdb_valid,
  input  logic [TW-1:0] cdb_tag,
  input  logic [DW-1:0] cdb_data
);
  logic [DW-1:0] val_q [NREG];
  logic [TW-1:0] tag_q [NREG];

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    logic hit;
    assign hit = cdb_valid && (tag_q[r] != '0) && (tag_q[r] == cdb_tag);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        val_q[r] <= DW'(reg_init(r));
        tag_q[r] <= '0;
      end else begin
        if (hit) begin
          val_q[r] <= cdb_data;
          tag_q[r] <= '0;
        end
        if (alloc_en && alloc_dst == RW'(r)) tag_q[r] <= alloc_tag;
      end
    end

    AST_STALE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (cdb_valid && tag_q[r] != cdb_tag) |=> (val_q[r] == $past(val_q[r]))); // R6
  end

  assign rv1      = val_q[ra1];
  assign rt1      = tag_q[ra1];
  assign rv2      = val_q[ra2];
  assign rt2      = tag_q[ra2];
  assign obs_val  = val_q[obs_addr];
  assign obs_busy = (tag_q[obs_addr] != '0);
endmodule

// File: rtl/rsb_station.sv
module rsb_station import rsb_pkg::*; #(
  parameter int DW     = 16,
  parameter int TW     = 3,
  parameter int MY_TAG = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc,
  input  logic [1:0]       alloc_op,
  input  logic [DW-1:0]    alloc_av,
  input  logic [TW-1:0]    alloc_at,
  input  logic [DW-1:0]    alloc_bv,
  input  logic [TW-1:0]    alloc_bt,
  input  logic [SEQ_W-1:0] alloc_seq,
  input  logic             go,
  input  logic             cdb_valid,
  input  logic [TW-1:0]    cdb_tag,
  input  logic [DW-1:0]    cdb_data,
  output st_e              state,
  output logic             rdy,
  output logic [1:0]       op,
  output logic [DW-1:0]    a_val,
  output logic [DW-1:0]    b_val,
  output logic [SEQ_W-1:0] seq
);
  logic [TW-1:0] a_tag, b_tag;
  logic          a_snoop, b_snoop, own_bcast;

  assign a_snoop   = cdb_valid && a_tag != '0 && cdb_tag == a_tag;
  assign b_snoop   = cdb_valid && b_tag != '0 && cdb_tag == b_tag;
  assign own_bcast = cdb_valid && cdb_tag == TW'(MY_TAG);
  assign rdy       = (state == ST_WAIT) && a_tag == '0 && b_tag == '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_EMPTY;
      op    <= '0;
      a_val <= '0;
      b_val <= '0;
      a_tag <= '0;
      b_tag <= '0;
      seq   <= '0;
    end else if (alloc) begin
      state <= ST_WAIT;
      op    <= alloc_op;
      a_val <= alloc_av;
      a_tag <= alloc_at;
      b_val <= alloc_bv;
      b_tag <= alloc_bt;
      seq   <= alloc_seq;
    end else begin
      case (state)
        ST_WAIT: begin
          if (a_snoop) begin a_val <= cdb_data; a_tag <= '0; end
          if (b_snoop) begin b_val <= cdb_data; b_tag <= '0; end
          if (go) state <= ST_EXEC;
        end
        ST_EXEC: if (own_bcast) state <= ST_EMPTY;
        default: ;
      endcase
    end
  end

  AST_BCAST_FROM_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
    own_bcast |-> (state == ST_EXEC)); // R10
  AST_FREED_AFTER_BCAST: assert property (@(posedge clk) disable iff (!rst_n)
    own_bcast |=> (state == ST_EMPTY)); // R4
  AST_GO_WITH_VALUES: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> (state == ST_WAIT && a_tag == '0 && b_tag == '0)); // R10
endmodule

// File: rtl/rsb_fu.sv
module rsb_fu import rsb_pkg::*; #(
  parameter int DW  = 16,
  parameter int TW  = 3,
  parameter int LAT = 1,
  localparam int CW = (LAT > 1) ? $clog2(LAT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       s_op,
  input  logic [DW-1:0]    s_a,
  input  logic [DW-1:0]    s_b,
  input  logic [TW-1:0]    s_tag,
  input  logic [SEQ_W-1:0] s_seq,
  input  logic             grant,
  output logic             idle,
  output logic             done,
  output logic [DW-1:0]    res,
  output logic [TW-1:0]    res_tag,
  output logic [SEQ_W-1:0] res_seq
);
  logic          busy;
  logic [CW-1:0] cnt;

  assign idle = !busy;
  assign done = busy && cnt == '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      cnt     <= '0;
      res     <= '0;
      res_tag <= '0;
      res_seq <= '0;
    end else if (start) begin
      busy    <= 1'b1;
      cnt     <= CW'(LAT - 1);
      res     <= DW'(op_eval(op_e'(s_op), 32'(s_a), 32'(s_b)));
      res_tag <= s_tag;
      res_seq <= s_seq;
    end else if (busy) begin
      if (cnt != '0) cnt <= cnt - 1'b1;
      else if (grant) busy <= 1'b0;
    end
  end

  AST_GRANT_ONLY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> done); // R8
  AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy); // R10
endmodule

// File: rtl/rsb_core.sv
module rsb_core import rsb_pkg::*; #(
  parameter int NREG    = 8,
  parameter int DW      = 16,
  parameter int ADD_RS  = 2,
  parameter int MUL_RS  = 2,
  parameter int ADD_LAT = 1,
  parameter int MUL_LAT = 3,
  localparam int NRS = ADD_RS + MUL_RS,
  localparam int TW  = $clog2(NRS + 1),
  localparam int IW  = (NRS > 1) ? $clog2(NRS) : 1,
  localparam int RW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [1:0]    in_op,
  input  logic [RW-1:0] in_dst,
  input  logic [RW-1:0] in_src1,
  input  logic [RW-1:0] in_src2,
  output logic          in_ready,
  input  logic [RW-1:0] rd_addr,
  output logic [DW-1:0] rd_val,
  output logic          rd_busy,
  output logic          cdb_valid,
  output logic [TW-1:0] cdb_tag,
  output logic [DW-1:0] cdb_data
);
  localparam int NFU = 2;

  st_e                          st_state [NRS];
  logic [NRS-1:0]               st_empty, st_rdy, st_alloc, st_go;
  logic [NRS-1:0][1:0]          st_op;
  logic [NRS-1:0][DW-1:0]       st_a, st_b;
  logic [NRS-1:0][SEQ_W-1:0]    st_seq;

  logic [NFU-1:0]               fu_start, fu_done, fu_grant;
  logic [NFU-1:0][IW-1:0]       fu_pick;
  logic [NFU-1:0][DW-1:0]       fu_res;
  logic [NFU-1:0][TW-1:0]       fu_tag;
  logic [NFU-1:0][SEQ_W-1:0]    fu_seq;

  // Issue: lowest empty station of the needed kind.
  logic          need_mul, alloc_found, issue;
  logic [IW-1:0] alloc_idx;
  logic [SEQ_W-1:0] seq_q;

  assign need_mul = (in_op == 2'(OP_MUL));

  always_comb begin
    alloc_found = 1'b0;
    alloc_idx   = '0;
    for (int i = 0; i < NRS; i++) begin
      if (!alloc_found && st_empty[i] && ((i >= ADD_RS) == need_mul)) begin
        alloc_found = 1'b1;
        alloc_idx   = IW'(i);
      end
    end
  end

  assign in_ready = alloc_found;
  assign issue    = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) seq_q <= '0;
    else if (issue) seq_q <= seq_q + 1'b1;
  end

  // Register read with same-cycle bus forwarding.
  logic [DW-1:0] rv1, rv2, src_av, src_bv;
  logic [TW-1:0] rt1, rt2, src_at, src_bt;
  logic          fwd1, fwd2;

  rsb_regfile #(.NREG(NREG), .DW(DW), .TW(TW)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .ra1(in_src1), .ra2(in_src2),
    .rv1(rv1), .rt1(rt1), .rv2(rv2), .rt2(rt2),
    .obs_addr(rd_addr), .obs_val(rd_val), .obs_busy(rd_busy),
    .alloc_en(issue), .alloc_dst(in_dst), .alloc_tag(TW'(alloc_idx) + 1'b1),
    .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_data(cdb_data)
  );

  assign fwd1   = rt1 != '0 && cdb_valid && cdb_tag == rt1;
  assign fwd2   = rt2 != '0 && cdb_valid && cdb_tag == rt2;
  assign src_av = fwd1 ? cdb_data : rv1;
  assign src_at = fwd1 ? '0 : rt1;
  assign src_bv = fwd2 ? cdb_data : rv2;
  assign src_bt = fwd2 ? '0 : rt2;

  // Stations.
  for (genvar i = 0; i < NRS; i++) begin : g_rs
    localparam int U = (i < ADD_RS) ? 0 : 1;
    assign st_alloc[i] = issue && alloc_idx == IW'(i);
    assign st_go[i]    = fu_start[U] && fu_pick[U] == IW'(i);
    assign st_empty[i] = (st_state[i] == ST_EMPTY);

    rsb_station #(.DW(DW), .TW(TW), .MY_TAG(i + 1)) u_rs (
      .clk(clk), .rst_n(rst_n),
      .alloc(st_alloc[i]), .alloc_op(in_op),
      .alloc_av(src_av), .alloc_at(src_at),
      .alloc_bv(src_bv), .alloc_bt(src_bt),
      .alloc_seq(seq_q), .go(st_go[i]),
      .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_data(cdb_data),
      .state(st_state[i]), .rdy(st_rdy[i]), .op(st_op[i]),
      .a_val(st_a[i]), .b_val(st_b[i]), .seq(st_seq[i])
    );
  end

  // Functional units: 0 adds, 1 multiplies.
  for (genvar u = 0; u < NFU; u++) begin : g_fu
    localparam int LO = (u == 0) ? 0 : ADD_RS;
    localparam int HI = (u == 0) ? ADD_RS : NRS;
    localparam int LT = (u == 0) ? ADD_LAT : MUL_LAT;
    logic          idle, start;
    logic [IW-1:0] pick;

    always_comb begin
      start = 1'b0;
      pick  = '0;
      for (int i = LO; i < HI; i++) begin
        if (!start && idle && st_rdy[i]) begin
          start = 1'b1;
          pick  = IW'(i);
        end
      end
    end

    assign fu_start[u] = start;
    assign fu_pick[u]  = pick;

    rsb_fu #(.DW(DW), .TW(TW), .LAT(LT)) u_fu (
      .clk(clk), .rst_n(rst_n),
      .start(start), .s_op(st_op[pick]), .s_a(st_a[pick]), .s_b(st_b[pick]),
      .s_tag(TW'(pick) + 1'b1), .s_seq(st_seq[pick]),
      .grant(fu_grant[u]), .idle(idle), .done(fu_done[u]),
      .res(fu_res[u]), .res_tag(fu_tag[u]), .res_seq(fu_seq[u])
    );
  end

  // Result bus: oldest finished result wins.
  logic                   win_found;
  logic [$clog2(NFU)-1:0] win;

  always_comb begin
    win_found = 1'b0;
    win       = '0;
    for (int u = 0; u < NFU; u++) begin
      if (fu_done[u] && (!win_found || seq_older(fu_seq[u], fu_seq[win]))) begin
        win_found = 1'b1;
        win       = ($clog2(NFU))'(u);
      end
    end
    for (int u = 0; u < NFU; u++)
      fu_grant[u] = win_found && win == ($clog2(NFU))'(u);
  end

  assign cdb_valid = win_found;
  assign cdb_tag   = fu_tag[win];
  assign cdb_data  = fu_res[win];

  AST_STALL_ONLY_FULL_ADD: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && !need_mul) |-> (st_empty[ADD_RS-1:0] == '0)); // R4
  AST_STALL_ONLY_FULL_MUL: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && need_mul) |-> (st_empty[NRS-1:ADD_RS] == '0)); // R4
endmodule

// File: tb/rsb_core_test.sv
`timescale 1ns/1ps
module rsb_core_test;
  localparam int NREG = 8, DW = 16, ADD_RS = 2, MUL_RS = 2;
  localparam int TW = $clog2(ADD_RS + MUL_RS + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [1:0] in_op = 2'd0;
  logic [2:0] in_dst = '0, in_src1 = '0, in_src2 = '0, rd_addr = '0;
  logic in_ready, rd_busy, cdb_valid;
  logic [DW-1:0] rd_val, cdb_data;
  logic [TW-1:0] cdb_tag;

  int n_chk = 0, n_bad = 0;
  logic [DW-1:0] mdl [NREG];

  always #2.5 clk = ~clk;

  rsb_core #(.NREG(NREG), .DW(DW), .ADD_RS(ADD_RS), .MUL_RS(MUL_RS), .ADD_LAT(1), .MUL_LAT(3)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op), .in_dst(in_dst),
    .in_src1(in_src1), .in_src2(in_src2), .in_ready(in_ready), .rd_addr(rd_addr),
    .rd_val(rd_val), .rd_busy(rd_busy), .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_data(cdb_data)
  );

  // Program: {op, dst, src1, src2}
  localparam logic [10:0] PROG [0:11] = '{
    {2'd3, 3'd1, 3'd2, 3'd3}, {2'd0, 3'd4, 3'd1, 3'd1}, {2'd1, 3'd1, 3'd5, 3'd6},
    {2'd3, 3'd7, 3'd1, 3'd4}, {2'd2, 3'd0, 3'd7, 3'd4}, {2'd0, 3'd2, 3'd2, 3'd0},
    {2'd3, 3'd2, 3'd2, 3'd2}, {2'd1, 3'd3, 3'd2, 3'd1}, {2'd0, 3'd5, 3'd3, 3'd7},
    {2'd3, 3'd6, 3'd5, 3'd6}, {2'd2, 3'd4, 3'd6, 3'd3}, {2'd0, 3'd0, 3'd4, 3'd4}
  };

  function automatic logic [DW-1:0] ref_op(int op, logic [DW-1:0] a, logic [DW-1:0] b);
    logic [31:0] p;
    if (op == 0) return a + b;
    if (op == 1) return a + (~b + 1'b1);
    if (op == 2) return a & b;
    p = {16'd0, a} * {16'd0, b};
    return p[DW-1:0];
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic issue(input int op, input int d, input int a, input int b);
    @(negedge clk);
    in_valid = 1'b1; in_op = 2'(op); in_dst = 3'(d); in_src1 = 3'(a); in_src2 = 3'(b);
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    mdl[d] = ref_op(op, mdl[a], mdl[b]);
    #1 in_valid = 1'b0;
  endtask

  task automatic check_regs(input string req);
    for (int r = 0; r < NREG; r++) begin
      @(negedge clk);
      rd_addr = 3'(r);
      #1;
      chk(rd_val == mdl[r] && !rd_busy, req, rd_val, mdl[r]);
    end
  endtask

  task automatic drain();
    repeat (30) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [DW-1:0] exp_m, exp_a;
    int guard;
    for (int r = 0; r < NREG; r++) mdl[r] = DW'(3 * r + 1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    @(negedge clk); #1;
    chk(in_ready == 1'b1, "R1 ready", in_ready, 1);
    chk(cdb_valid == 1'b0, "R1 bus idle", cdb_valid, 0);
    check_regs("R1 reset value");

    // R2 R5 R6: table walk, back to back
    for (int k = 0; k < 12; k++)
      issue(PROG[k][10:9], PROG[k][8:6], PROG[k][5:3], PROG[k][2:0]);
    drain();
    check_regs("R2 R5 R6 program result");

    // R5 R6: divide-like slow producer, reader, fast overwriter, reader
    issue(3, 0, 1, 2);
    issue(0, 3, 0, 1);
    issue(1, 0, 4, 5);
    issue(3, 6, 0, 4);
    drain();
    check_regs("R5 R6 renamed sequence");

    // R9 R8 R3: latency, collision ordering, tags
    @(negedge clk);
    in_valid = 1'b1; in_op = 2'd3; in_dst = 3'd2; in_src1 = 3'd3; in_src2 = 3'd4;
    exp_m = ref_op(3, mdl[3], mdl[4]); mdl[2] = exp_m;
    @(posedge clk); #1 in_valid = 1'b0;
    @(negedge clk);
    chk(cdb_valid == 1'b0, "R9 bus quiet after E0", cdb_valid, 0);
    rd_addr = 3'd2; #1;
    chk(rd_busy == 1'b1, "R5 destination pending", rd_busy, 1);
    @(negedge clk);
    chk(cdb_valid == 1'b0, "R9 bus quiet after E1", cdb_valid, 0);
    in_valid = 1'b1; in_op = 2'd0; in_dst = 3'd7; in_src1 = 3'd5; in_src2 = 3'd6;
    exp_a = ref_op(0, mdl[5], mdl[6]); mdl[7] = exp_a;
    @(posedge clk); #1 in_valid = 1'b0;
    @(negedge clk);
    chk(cdb_valid == 1'b0, "R9 bus quiet after E2", cdb_valid, 0);
    @(negedge clk);
    chk(cdb_valid && cdb_data == exp_m, "R9 R8 multiply first", cdb_data, exp_m);
    chk(cdb_tag == TW'(ADD_RS + 1), "R3 multiply tag", cdb_tag, ADD_RS + 1);
    @(negedge clk);
    chk(cdb_valid && cdb_data == exp_a, "R8 add second", cdb_data, exp_a);
    chk(cdb_tag == TW'(1), "R3 add tag", cdb_tag, 1);
    drain();

    // R7: issue while source result is on the bus
    issue(3, 1, 2, 3);
    guard = 0;
    @(negedge clk); #1;
    while (!cdb_valid && guard < 20) begin @(negedge clk); #1; guard++; end
    in_valid = 1'b1; in_op = 2'd0; in_dst = 3'd4; in_src1 = 3'd1; in_src2 = 3'd1;
    mdl[4] = ref_op(0, mdl[1], mdl[1]);
    @(posedge clk); #1 in_valid = 1'b0;
    drain();
    @(negedge clk); rd_addr = 3'd4; #1;
    chk(rd_val == mdl[4] && !rd_busy, "R7 forwarded operand", rd_val, mdl[4]);

    // R4: stall only for the full kind
    issue(3, 1, 2, 3);
    issue(3, 4, 1, 1);
    @(negedge clk);
    in_op = 2'd3; #1;
    chk(in_ready == 1'b0, "R4 multiplier stations full", in_ready, 0);
    in_op = 2'd0; #1;
    chk(in_ready == 1'b1, "R4 adder stations free", in_ready, 1);
    issue(3, 5, 4, 2);
    drain();
    check_regs("R4 R5 after stall");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule